// File: doc/BRIEF.md
# Encoded-Ratio Bus Clock Divider Bank

This block turns one fast clock into a set of clock-enable strobes for the main buses of a chip. The strobes cover the core, a high-speed peripheral bus, a low-speed peripheral bus and the memory interface, plus a display pixel strobe, a device strobe, a half-rate branch strobe and a clock-out strobe. A 32-bit control word, written through a simple write port and always visible on a read port, sets every ratio.

Each of the four main domains takes a 4-bit code. The code picks a divisor from a fixed, partly non-power-of-two set. A code change waits until the running period of that domain ends, so no strobe period is ever cut short. A change-enable bit can hold the main ratios at their current values while new codes are staged. The display and device strobes count the half-rate branch strobe with plain value-plus-one dividers.

Top module: `clk_ratio_bank`

## Requirements
- R1: After synchronous reset the control word reads 0 and every bit of `ratio_ce` is high on every cycle (divide-by-1).
- R2: `ratio_ce[0]`, `[1]`, `[2]`, `[3]` (core, high-speed, low-speed, memory) take their codes from bits 3:0, 7:4, 11:8 and 15:12. Codes 0..9 give strobe periods 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 cycles.
- R3: A main ratio code from 10 to 15 gives a period of 32 cycles.
- R4: For any divisor N above 1, the strobe is high for exactly one cycle in every N cycles, including odd N such as 3.
- R5: A new main code takes effect only at the end of the period that is running, which keeps its full old length. The next period has the new length.
- R6: While bit 22 (change enable) is 0, the four main dividers keep their current divisors whatever codes are written. Once bit 22 is 1, the stored codes are applied.
- R7: Bit 21 = 1 makes `half_ce` high every cycle. Bit 21 = 0 makes it high every second cycle.
- R8: `lcd_ce` pulses once per (L+1) `half_ce` strobes, where L is bits 20:16.
- R9: `dev_ce` pulses once per (D+1) `half_ce` strobes, where D is bits 28:23.
- R10: When bit 30 is 1, `cko_ce` repeats the memory strobe cycle for cycle. When bit 30 is 0, `cko_ce` stays low.
- R11: A write stores `wr_data` on the next edge, and `rd_data` shows it with bits 29 and 31 forced to 0. Without a write the word is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Current control word |
| ratio_ce | output | 4 | Main-domain strobes: core, high-speed, low-speed, memory |
| half_ce | output | 1 | Half-rate branch strobe |
| lcd_ce | output | 1 | Display pixel strobe |
| dev_ce | output | 1 | Device strobe |
| cko_ce | output | 1 | Clock-out strobe, gated copy of the memory strobe |

## Verification
A wrong count or divisor register shows up at the ports as a strobe interval that differs from the code written. The bench measures these intervals after each configuration settles, so an error appears within one or two strobe periods of at most 128 cycles. A divisor loaded at the wrong moment shows up as a shortened or stretched interval just after a code change. This is checked on the exact period that spans the write. A failure to hold codes while change enable is clear shows up as the old interval continuing or not continuing.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

  localparam int CTRL_W   = 32;
  localparam int RATIO_W  = 4;
  localparam int NUM_MAIN = 4;
  localparam int DIV_W    = 6;
  localparam int LCD_W    = 5;
  localparam int DEV_W    = 6;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'h5FFF_FFFF;

  typedef enum logic [1:0] {DOM_CORE, DOM_HSP, DOM_LSP, DOM_MEM} dom_e;

  // Control word layout, most significant field first.
  typedef struct packed {
    logic              spare_hi;
    logic              cko_en;
    logic              spare_mid;
    logic [DEV_W-1:0]  dev_div;
    logic              chg_en;
    logic              half_full;
    logic [LCD_W-1:0]  lcd_div;
    logic [RATIO_W-1:0] mem_code;
    logic [RATIO_W-1:0] lsp_code;
    logic [RATIO_W-1:0] hsp_code;
    logic [RATIO_W-1:0] core_code;
  } ctrl_t;

  // Encoded ratio set; everything past the end clamps to the slowest entry.
  function automatic logic [DIV_W-1:0] ratio_divisor(input logic [RATIO_W-1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = 6'd1;
      4'd1:    d = 6'd2;
      4'd2:    d = 6'd3;
      4'd3:    d = 6'd4;
      4'd4:    d = 6'd6;
      4'd5:    d = 6'd8;
      4'd6:    d = 6'd12;
      4'd7:    d = 6'd16;
      4'd8:    d = 6'd24;
      default: d = 6'd32;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cdb_ctrl_reg.sv
module cdb_ctrl_reg #(
  parameter int                W     = 32,
  parameter logic [W-1:0]      WMASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= wr_data & WMASK;
    end
  end

  p_write_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q == ($past(wr_data) & WMASK)));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/cdb_half_branch.sv
module cdb_half_branch (
  input  logic clk,
  input  logic rst,
  input  logic full_sel,
  output logic ce_o
);

  logic phase_q;
  logic ce_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      ce_q    <= full_sel | phase_q;
    end
  end

  assign ce_o = ce_q;

  // Half-rate mode never gives two strobes in a row.
  p_half_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (ce_q && !$past(full_sel) && !full_sel) |=> !ce_q);

endmodule

// File: rtl/cdb_ratio_div.sv
module cdb_ratio_div #(
  parameter int CNT_W    = 6,
  parameter bit FREE_RUN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_ce,
  input  logic             apply_en,
  input  logic [CNT_W-1:0] next_div,
  input  logic             tap_en,
  output logic             pulse_o,
  output logic             tap_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_q;
  logic             pulse_q;
  logic             tap_q;
  logic             tick;

  // Terminal count: last input strobe of the running period.
  assign tick = in_ce && (cnt_q == div_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      div_q   <= ONE;
      pulse_q <= 1'b0;
      tap_q   <= 1'b0;
    end else begin
      pulse_q <= tick;
      tap_q   <= tick && tap_en;
      if (in_ce) begin
        if (tick) begin
          cnt_q <= '0;
          // A new divisor is loaded only here, so a period is never cut.
          if (apply_en && (next_div != '0)) begin
            div_q <= next_div;
          end
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end

  assign pulse_o = pulse_q;
  assign tap_o   = tap_q;

  p_one_hot_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && (div_q != ONE)) |=> !pulse_q);

  generate
    if (FREE_RUN) begin : g_period_chk
      logic [CNT_W+1:0] cyc_q;
      logic [CNT_W-1:0] per_q;
      logic             seen_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cyc_q  <= '0;
          per_q  <= '0;
          seen_q <= 1'b0;
        end else begin
          if (pulse_q) begin
            cyc_q  <= (CNT_W+2)'(1);
            per_q  <= div_q;
            seen_q <= 1'b1;
          end else if (cyc_q != '1) begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
      end

      // Every completed period is exactly the length in force when it began.
      p_full_period_r5: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && seen_q) |-> (cyc_q == {2'b00, per_q}));
    end
  endgenerate

endmodule

// File: rtl/clk_ratio_bank.sv
module clk_ratio_bank
  import cdb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CTRL_W-1:0]   wr_data,
  output logic [CTRL_W-1:0]   rd_data,
  output logic [NUM_MAIN-1:0] ratio_ce,
  output logic                half_ce,
  output logic                lcd_ce,
  output logic                dev_ce,
  output logic                cko_ce
);

  localparam int LCD_CNT_W = LCD_W + 1;
  localparam int DEV_CNT_W = DEV_W + 1;

  logic [CTRL_W-1:0]   ctrl_q;
  ctrl_t               cfg;
  logic [NUM_MAIN-1:0] main_tap;
  logic                lcd_tap;
  logic                dev_tap;
  logic [LCD_CNT_W-1:0] lcd_next;
  logic [DEV_CNT_W-1:0] dev_next;

  cdb_ctrl_reg #(.W(CTRL_W), .WMASK(CTRL_WMASK)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  assign cfg     = ctrl_t'(ctrl_q);
  assign rd_data = ctrl_q;

  // Four main domains share one decode and divider structure.
  generate
    for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main
      logic [RATIO_W-1:0] code;
      logic [DIV_W-1:0]   divv;
      logic               tap_sel;

      assign code    = ctrl_q[i*RATIO_W +: RATIO_W];
      assign divv    = ratio_divisor(code);
      assign tap_sel = (i == int'(DOM_MEM)) ? cfg.cko_en : 1'b0;

      cdb_ratio_div #(.CNT_W(DIV_W), .FREE_RUN(1'b1)) u_div (
        .clk      (clk),
        .rst      (rst),
        .in_ce    (1'b1),
        .apply_en (cfg.chg_en),
        .next_div (divv),
        .tap_en   (tap_sel),
        .pulse_o  (ratio_ce[i]),
        .tap_o    (main_tap[i])
      );

      p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(code) >= 10) |-> (int'(divv) == 32));
    end
  endgenerate

  cdb_half_branch u_half (
    .clk      (clk),
    .rst      (rst),
    .full_sel (cfg.half_full),
    .ce_o     (half_ce)
  );

  assign lcd_next = {1'b0, cfg.lcd_div} + LCD_CNT_W'(1);
  assign dev_next = {1'b0, cfg.dev_div} + DEV_CNT_W'(1);

  cdb_ratio_div #(.CNT_W(LCD_CNT_W), .FREE_RUN(1'b0)) u_lcd (
    .clk      (clk),
    .rst      (rst),
    .in_ce    (half_ce),
    .apply_en (1'b1),
    .next_div (lcd_next),
    .tap_en   (1'b0),
    .pulse_o  (lcd_ce),
    .tap_o    (lcd_tap)
  );

  cdb_ratio_div #(.CNT_W(DEV_CNT_W), .FREE_RUN(1'b0)) u_dev (
    .clk      (clk),
    .rst      (rst),
    .in_ce    (half_ce),
    .apply_en (1'b1),
    .next_div (dev_next),
    .tap_en   (1'b0),
    .pulse_o  (dev_ce),
    .tap_o    (dev_tap)
  );

  // Only the memory divider has its tap enabled; the other taps stay low.
  assign cko_ce = |{main_tap, lcd_tap, dev_tap};

  p_cko_follow_r10: assert property (@(posedge clk) disable iff (rst)
    cko_ce |-> ratio_ce[DOM_MEM]);

  p_cko_gate_r10: assert property (@(posedge clk) disable iff (rst)
    cko_ce |-> $past(cfg.cko_en));

endmodule

// File: tb/clk_ratio_bank_bench.sv
`timescale 1ns/1ps
module clk_ratio_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  ratio_ce;
  logic        half_ce, lcd_ce, dev_ce, cko_ce;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Scoreboard: kind 0 = period, 1 = high count in 96 cycles, 2 = high count in 200 cycles.
  int    q_sel[$];
  int    q_kind[$];
  int    q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  clk_ratio_bank u_clk_ratio_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ratio_ce(ratio_ce), .half_ce(half_ce), .lcd_ce(lcd_ce), .dev_ce(dev_ce), .cko_ce(cko_ce)
  );

  function automatic logic sig(input int sel);
    case (sel)
      0, 1, 2, 3: return ratio_ce[sel];
      4:          return half_ce;
      5:          return lcd_ce;
      6:          return dev_ce;
      default:    return cko_ce;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int core, input int hsp, input int lsp, input int mem,
                                     input int lcd, input bit full, input bit ce, input int dev,
                                     input bit cko);
    logic [31:0] v;
    v = '0;
    v[3:0]   = core[3:0];
    v[7:4]   = hsp[3:0];
    v[11:8]  = lsp[3:0];
    v[15:12] = mem[3:0];
    v[20:16] = lcd[4:0];
    v[21]    = full;
    v[22]    = ce;
    v[28:23] = dev[5:0];
    v[30]    = cko;
    return v;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic find_high(input int sel, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (sig(sel)) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic interval(input int sel, output int per);
    bit hit = 1'b0;
    int c = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      c++;
      if (sig(sel)) begin
        hit = 1'b1;
        break;
      end
    end
    per = hit ? c : -1;
  endtask

  task automatic measure_period(input int sel, output int per);
    bit ok;
    int dummy;
    find_high(sel, ok);
    if (!ok) begin
      per = -1;
    end else begin
      interval(sel, dummy);
      interval(sel, per);
    end
  endtask

  task automatic count_highs(input int sel, input int len, output int cnt);
    cnt = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (sig(sel)) cnt++;
    end
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic expect_item(input int sel, input int kind, input int exp, input string tag);
    q_sel.push_back(sel);
    q_kind.push_back(kind);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    while (q_sel.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares them with measured behaviour.
  initial begin
    forever begin
      @(negedge clk);
      if (q_sel.size() > 0) begin
        int act;
        case (q_kind[0])
          0:       measure_period(q_sel[0], act);
          1:       count_highs(q_sel[0], 96, act);
          default: count_highs(q_sel[0], 200, act);
        endcase
        check(q_tag[0], $sformatf("strobe %0d kind %0d", q_sel[0], q_kind[0]), act, q_exp[0]);
        void'(q_sel.pop_front());
        void'(q_kind.pop_front());
        void'(q_exp.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int per;
    bit ok;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "control word after reset", int'(rd_data), 0);
    check("R1", "main strobes after reset", int'(ratio_ce), 15);
    expect_item(0, 1, 96, "R1");
    expect_item(3, 0, 1, "R1");
    expect_item(4, 0, 2, "R7");
    expect_item(5, 0, 2, "R8");
    expect_item(6, 0, 2, "R9");
    drain();

    // Config A: codes 0..3, full-rate branch, clock-out on.
    write_ctrl(mk(0, 1, 2, 3, 4, 1'b1, 1'b1, 5, 1'b1));
    expect_item(0, 0, 1, "R2");
    expect_item(1, 0, 2, "R2");
    expect_item(2, 0, 3, "R2");
    expect_item(2, 1, 32, "R4");
    expect_item(3, 0, 4, "R2");
    expect_item(4, 0, 1, "R7");
    expect_item(5, 0, 5, "R8");
    expect_item(6, 0, 6, "R9");
    expect_item(7, 0, 4, "R10");
    expect_item(7, 1, 24, "R10");
    drain();

    // Config B: codes 4..7, half-rate branch, clock-out off.
    write_ctrl(mk(4, 5, 6, 7, 0, 1'b0, 1'b1, 63, 1'b0));
    expect_item(0, 0, 6, "R2");
    expect_item(1, 0, 8, "R2");
    expect_item(2, 0, 12, "R2");
    expect_item(3, 0, 16, "R2");
    expect_item(4, 0, 2, "R7");
    expect_item(5, 0, 2, "R8");
    expect_item(6, 0, 128, "R9");
    expect_item(7, 2, 0, "R10");
    drain();

    // Config C: codes 8, 9 and clamped codes 10 and 15.
    write_ctrl(mk(8, 9, 10, 15, 31, 1'b1, 1'b1, 0, 1'b1));
    expect_item(0, 0, 24, "R2");
    expect_item(1, 0, 32, "R2");
    expect_item(2, 0, 32, "R3");
    expect_item(3, 0, 32, "R3");
    expect_item(5, 0, 32, "R8");
    expect_item(6, 0, 1, "R9");
    expect_item(7, 0, 32, "R10");
    drain();

    // R11: readback with reserved bits dropped; all codes 15.
    write_ctrl(32'hFFFF_FFFF);
    check("R11", "readback of all ones", int'(rd_data), int'(32'h5FFF_FFFF));
    expect_item(0, 0, 32, "R3");
    expect_item(6, 0, 64, "R9");
    drain();

    // R6: hold while change enable is clear.
    write_ctrl(mk(2, 0, 0, 0, 0, 1'b1, 1'b1, 0, 1'b0));
    expect_item(0, 0, 3, "R6");
    expect_item(1, 0, 1, "R6");
    drain();
    write_ctrl(mk(5, 3, 0, 0, 0, 1'b1, 1'b0, 0, 1'b0));
    check("R11", "staged code readback", int'(rd_data), int'(mk(5, 3, 0, 0, 0, 1'b1, 1'b0, 0, 1'b0)));
    expect_item(0, 0, 3, "R6");
    expect_item(1, 0, 1, "R6");
    drain();
    write_ctrl(mk(5, 3, 0, 0, 0, 1'b1, 1'b1, 0, 1'b0));
    expect_item(0, 0, 8, "R6");
    expect_item(1, 0, 4, "R6");
    drain();

    // R5: switch from 32 to 1 just after a strobe; the running period completes.
    write_ctrl(mk(9, 0, 0, 0, 0, 1'b1, 1'b1, 0, 1'b0));
    expect_item(0, 0, 32, "R5");
    drain();
    find_high(0, ok);
    check("R5", "strobe found before change", int'(ok), 1);
    wr_en   = 1'b1;
    wr_data = mk(0, 0, 0, 0, 0, 1'b1, 1'b1, 0, 1'b0);
    per = -1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (sig(0)) begin
        per = k;
        break;
      end
    end
    check("R5", "period spanning the change", per, 32);
    interval(0, per);
    check("R5", "first period after the change", per, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule